// File: doc/BRIEF.md
# Audio Sample-Rate Strobe Generator

This block turns one fast input clock into the timing pulses of an audio subsystem. A control register sets three things: whether the input comes straight from the master clock pin or from a PLL, how many input cycles make up one base sample period, and a core enable. From these the block produces a one-cycle strobe at the base sample rate. With a 49.152 MHz input and a ratio of 1024, that rate is 48 kHz.

Three further channels each make their own strobe at a multiple or a fraction of the base rate. One channel serves the converters, one the DSP and one the serial port. Each channel has its own selector.

Every strobe comes from a counter of input cycles. Its period is the base ratio times the chosen divisor. The divisors include 0.5 and 1.5, so the period is computed in half base periods. Configuration is written through a small register port. A new configuration is held and applied only at a base-period boundary, and at that point all counters restart together. This keeps the derived strobes in phase with the base strobe.

Top module: `sr_strobe_gen`

## Requirements
- R1: After reset every strobe is low. Reset leaves the core disabled, selects the direct input, sets the ratio code to 0 (256 cycles per base period when BASE_UNIT is 256) and sets every selector code to 0 (divide by 1).
- R2: While the applied enable (control bit 0) is 0, no strobe is asserted. A write that clears the enable applies at the next base boundary. The strobes stop after that boundary.
- R3: With the direct input (control bit 3 = 0), the ratio field in control bits [2:1] with code k gives a base period of (k+1)×BASE_UNIT input cycles. For BASE_UNIT of 256 the codes give 256, 512, 768 and 1024.
- R4: With control bit 3 = 1, the base period is 4×BASE_UNIT cycles, whatever the ratio field holds.
- R5: A selector code sets its channel's period as a multiple of the base period P, as follows:
  - code 0 gives P;
  - code 1 gives 6P;
  - code 2 gives 4P;
  - code 3 gives 3P;
  - code 4 gives 2P;
  - code 5 gives 1.5P;
  - code 6 gives 0.5P;
  - code 7, and DSP codes 8 to 15, give P.
- R6: The write port decodes the address as follows. Bits [3:0] of the data are written into the addressed register, and any other address is ignored, with no effect on any strobe.
  - Address 0 is the control register.
  - Address 1 is the converter selector, data bits [2:0].
  - Address 2 is the DSP selector, data bits [3:0].
  - Address 3 is the serial-port selector, data bits [2:0].
- R7: While the core is disabled, a write takes effect on the clock edge after the edge that samples it. Call that edge T. Each channel with period Q then strobes for one cycle at exactly T+Q, T+2Q, and so on.
- R8: While the core is enabled, a write takes effect at the edge A where the base strobe next rises after the write. The old settings govern every strobe up to and including edge A. After edge A, each channel strobes at A+Q, A+2Q, and so on, using the new settings.
- R9: A channel with an integer divisor strobes only together with the base strobe. A channel at divide-by-0.5 strobes together with every base strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock; all counting is in its cycles |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW (3) | Register address |
| wr_data | input | 4 | Register write data |
| base_stb | output | 1 | One-cycle strobe at the base sample rate |
| conv_stb | output | 1 | Converter-rate strobe |
| dsp_stb | output | 1 | DSP-rate strobe |
| ser_stb | output | 1 | Serial-port-rate strobe |

## Verification
The assertions watch, on every cycle:
- that no counter reaches its period;
- that the block stays silent while disabled;
- that integer-divisor wraps coincide with base wraps and that half-rate wraps cover every base wrap;
- that a change to the applied settings made while enabled happens only on a base-strobe edge.

The exact period of each ratio, source and selector code, the forcing of the ratio by the PLL source, the position of the first strobe after enabling, and the restart point after a write in mid-stream can only be shown by the bench. The bench sweeps every setting and compares each strobe against a cycle-exact model.

// File: rtl/sr_pkg.sv
package sr_pkg;

  // Applied / pending configuration of the strobe generator.
  typedef struct packed {
    logic       src;    // 1: PLL input, ratio forced to the largest
    logic [1:0] ratio;  // base period = (ratio+1) * BASE_UNIT
    logic       en;     // core enable
    logic [2:0] conv;   // converter rate selector
    logic [3:0] dsp;    // DSP rate selector
    logic [2:0] ser;    // serial-port rate selector
  } sr_cfg_t;

  localparam int NCH = 4;  // base + three derived channels

  localparam logic [3:0] SEL_HALF_RATE = 4'd6;

  // Channel period expressed in half base periods.
  function automatic logic [3:0] sel_halves(input logic [3:0] code);
    case (code)
      4'd1:    return 4'd12;
      4'd2:    return 4'd8;
      4'd3:    return 4'd6;
      4'd4:    return 4'd4;
      4'd5:    return 4'd3;
      4'd6:    return 4'd1;
      default: return 4'd2;
    endcase
  endfunction

  // True when the divisor is a whole number of base periods.
  function automatic logic sel_is_whole(input logic [3:0] code);
    return sel_halves(code)[0] == 1'b0;
  endfunction

endpackage

// File: rtl/sr_cfg_regs.sv
module sr_cfg_regs
  import sr_pkg::*;
#(
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [3:0]    wr_data,
  input  logic          boundary,
  output sr_cfg_t       act,
  output logic          apply
);

  sr_cfg_t pend, pend_wr;
  logic    dirty;
  logic    hit;

  always_comb begin
    pend_wr = pend;
    hit     = 1'b0;
    if (wr_en) begin
      case (wr_addr)
        AW'(0): begin
          pend_wr.src   = wr_data[3];
          pend_wr.ratio = wr_data[2:1];
          pend_wr.en    = wr_data[0];
          hit           = 1'b1;
        end
        AW'(1): begin pend_wr.conv = wr_data[2:0]; hit = 1'b1; end
        AW'(2): begin pend_wr.dsp  = wr_data;      hit = 1'b1; end
        AW'(3): begin pend_wr.ser  = wr_data[2:0]; hit = 1'b1; end
        default: hit = 1'b0;
      endcase
    end
  end

  // Apply at once while idle, otherwise only on a base boundary.
  assign apply = dirty && (!act.en || boundary);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend  <= '0;
      act   <= '0;
      dirty <= 1'b0;
    end else begin
      if (apply) begin
        act   <= pend;
        dirty <= 1'b0;
      end
      if (hit) begin
        pend  <= pend_wr;
        dirty <= 1'b1;
      end
    end
  end

  AST_IDLE_APPLY_PROMPT: assert property (@(posedge clk) disable iff (rst)
    (dirty && !act.en) |=> !dirty || $past(hit)); // R7

endmodule

// File: rtl/sr_rate_map.sv
module sr_rate_map
  import sr_pkg::*;
#(
  parameter int BASE_UNIT = 256,
  parameter int CW        = 13
) (
  input  sr_cfg_t       cfg,
  output logic [CW-1:0] per [NCH]
);

  logic [1:0]  eff_ratio;
  logic [31:0] base_cyc;
  logic [3:0]  code [NCH];

  assign eff_ratio = cfg.src ? 2'b11 : cfg.ratio;
  assign base_cyc  = (32'(eff_ratio) + 32'd1) * 32'(BASE_UNIT);

  assign code[0] = 4'd0;
  assign code[1] = {1'b0, cfg.conv};
  assign code[2] = cfg.dsp;
  assign code[3] = {1'b0, cfg.ser};

  for (genvar g = 0; g < NCH; g++) begin : g_per
    logic [31:0] cyc;
    assign cyc    = (base_cyc * 32'(sel_halves(code[g]))) >> 1;
    assign per[g] = CW'(cyc);
  end

endmodule

// File: rtl/sr_period_ctr.sv
module sr_period_ctr #(
  parameter int CW = 13
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          clr,
  input  logic [CW-1:0] period,
  output logic          stb,
  output logic          wrap
);

  logic [CW-1:0] cnt;

  assign wrap = en && (cnt == period - CW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      stb <= 1'b0;
    end else begin
      stb <= wrap;
      if (clr || !en || wrap) cnt <= '0;
      else                    cnt <= cnt + CW'(1);
    end
  end

  AST_CNT_BELOW_PERIOD: assert property (@(posedge clk) disable iff (rst)
    en |-> cnt < period); // R3

endmodule

// File: rtl/sr_strobe_gen.sv
module sr_strobe_gen
  import sr_pkg::*;
#(
  parameter int BASE_UNIT = 256,
  parameter int AW        = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [3:0]    wr_data,
  output logic          base_stb,
  output logic          conv_stb,
  output logic          dsp_stb,
  output logic          ser_stb
);

  localparam int CW = $clog2(24 * BASE_UNIT + 1);

  sr_cfg_t       act;
  logic          apply;
  logic [CW-1:0] per [NCH];
  logic [NCH-1:0] stb, wrap;
  logic [3:0]    sel [NCH];

  sr_cfg_regs #(.AW(AW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .boundary(wrap[0]), .act(act), .apply(apply)
  );

  sr_rate_map #(.BASE_UNIT(BASE_UNIT), .CW(CW)) u_map (
    .cfg(act), .per(per)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    sr_period_ctr #(.CW(CW)) u_ctr (
      .clk(clk), .rst(rst), .en(act.en), .clr(apply),
      .period(per[g]), .stb(stb[g]), .wrap(wrap[g])
    );
  end

  assign base_stb = stb[0];
  assign conv_stb = stb[1];
  assign dsp_stb  = stb[2];
  assign ser_stb  = stb[3];

  assign sel[0] = 4'd0;
  assign sel[1] = {1'b0, act.conv};
  assign sel[2] = act.dsp;
  assign sel[3] = {1'b0, act.ser};

  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    !$past(act.en) |-> stb == '0); // R2

  AST_SWITCH_ON_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    ($past(act.en) && act != $past(act)) |-> stb[0]); // R8

  for (genvar c = 1; c < NCH; c++) begin : g_align
    AST_WHOLE_ON_BASE: assert property (@(posedge clk) disable iff (rst)
      (wrap[c] && sel_is_whole(sel[c])) |-> wrap[0]); // R9
    AST_HALF_COVERS_BASE: assert property (@(posedge clk) disable iff (rst)
      (wrap[0] && sel[c] == SEL_HALF_RATE) |-> wrap[c]); // R9
  end

endmodule

// File: tb/sim_sr_strobe_gen.sv
module sim_sr_strobe_gen;
  localparam int BU = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [3:0] wr_data = '0;
  logic       base_stb, conv_stb, dsp_stb, ser_stb;

  sr_strobe_gen #(.BASE_UNIT(BU), .AW(3)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .base_stb(base_stb), .conv_stb(conv_stb), .dsp_stb(dsp_stb), .ser_stb(ser_stb)
  );

  always #10 clk = ~clk;

  int ecnt = 0;
  always @(posedge clk) ecnt <= ecnt + 1;

  int nchk = 0, nfail = 0;

  // Cycle-exact model: "o_" holds up to edge sw, "n_" after it.
  bit o_en = 0, n_en = 0;
  int o_t0 = 0, n_t0 = 0, sw = 0;
  int o_q [4] = '{BU, BU, BU, BU};
  int n_q [4] = '{BU, BU, BU, BU};
  bit c_src = 0, c_en = 0;
  int c_ratio = 0;
  int c_sel [3] = '{0, 0, 0};

  bit mon_on = 0;
  int mis  [4] = '{0, 0, 0, 0};
  int seen [4] = '{0, 0, 0, 0};

  function automatic int halves(input int code);
    case (code)
      1: return 12; 2: return 8; 3: return 6; 4: return 4;
      5: return 3;  6: return 1; default: return 2;
    endcase
  endfunction

  function automatic bit fires(input bit en, input int t0, input int q, input int n);
    return en && n > t0 && ((n - t0) % q == 0);
  endfunction

  always @(negedge clk) begin
    if (mon_on) begin
      for (int ch = 0; ch < 4; ch++) begin
        bit e, a;
        a = (ch == 0) ? base_stb : (ch == 1) ? conv_stb : (ch == 2) ? dsp_stb : ser_stb;
        if (ecnt > sw) e = fires(n_en, n_t0, n_q[ch], ecnt);
        else           e = fires(o_en, o_t0, o_q[ch], ecnt);
        if (a != e) mis[ch]++;
        if (a) seen[ch]++;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Write one register; model the switch point when the address is valid.
  task automatic wr(input int a, input int d);
    int w, p, a_edge, base;
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = 4'(d);
    @(negedge clk);
    w = ecnt;
    wr_en = 1'b0;
    if (a < 4) begin
      case (a)
        0: begin c_src = d[3]; c_ratio = (d >> 1) & 3; c_en = d[0]; end
        1: c_sel[0] = d & 7;
        2: c_sel[1] = d & 15;
        default: c_sel[2] = d & 7;
      endcase
      if (n_en) begin
        p = n_q[0];
        a_edge = n_t0 + ((w - n_t0) / p + 1) * p;
      end else begin
        a_edge = w + 1;
      end
      o_en = n_en; o_t0 = n_t0; o_q = n_q; sw = a_edge;
      base = (c_src ? 4 : c_ratio + 1) * BU;
      n_en = c_en; n_t0 = a_edge;
      n_q[0] = base;
      for (int c = 0; c < 3; c++) n_q[c+1] = base * halves(c_sel[c]) / 2;
    end
  endtask

  task automatic window(input int cycles);
    for (int c = 0; c < 4; c++) begin mis[c] = 0; seen[c] = 0; end
    repeat (cycles) @(negedge clk);
  endtask

  task automatic judge(input string req, input bit need_seen);
    for (int c = 0; c < 4; c++) begin
      check(mis[c] == 0, req, $sformatf("ch%0d mismatching cycles", c), mis[c], 0);
      if (need_seen) check(seen[c] > 0, req, $sformatf("ch%0d strobe count", c), seen[c], 1);
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check({base_stb, conv_stb, dsp_stb, ser_stb} == 4'b0, "R1", "strobes in reset",
          int'({base_stb, conv_stb, dsp_stb, ser_stb}), 0);
    rst = 1'b0;
    mon_on = 1'b1;
    window(60);
    judge("R1 R2 idle after reset", 1'b0);
    wr(0, 4'b0001);
    window(60);
    judge("R1 R7 default rates", 1'b1);

    for (int src = 0; src < 2; src++) begin
      for (int r = 0; r < 4; r++) begin
        for (int code = 0; code < 8; code++) begin
          int ctl, big;
          ctl = (src << 3) | (r << 1);
          wr(0, ctl);
          window(60);
          judge("R2 disabled", 1'b0);
          wr(1, code);
          wr(2, code + 8 * (code % 2));
          wr(3, (code + 3) % 8);
          wr(0, ctl | 1);
          big = (src ? 4 : r + 1) * BU * 6;
          window(2 * big + 8);
          judge(src ? "R4 R5 R7 R9 pll sweep" : "R3 R5 R7 R9 direct sweep", 1'b1);
          wr(4 + code % 4, 4'hF);
          window(big + 8);
          judge("R6 ignored address", 1'b0);
          wr(1, (code + 1) % 8);
          window(2 * big + 8);
          judge("R8 live update", 1'b1);
        end
      end
    end

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    #(200000 * 20);
    nchk++; nfail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

endmodule